// File: doc/BRIEF.md
# Dual-Lane Serial Word Shifter

This block is a synchronous serial engine that sends one 16-bit transmit word and captures one 16-bit receive word per frame. It can run on a single output/input line pair, or split each word across two line pairs so that a frame takes half as many serial clocks. The serial clock comes from the system clock through a selectable divider. Its idle level and its sampling edge are programmable, as in SPI.

While `en` is high, frames run back to back and the transmit word is taken in at the start of each frame. A separate update interval, counted in serial clocks from the moment the engine starts, decides when a finished receive word may be published. The receive word is published only when a frame ends exactly on an update point. A frame that ends at any other time is dropped and flagged as an overrun.

The engine is built from a four-state machine: `ST_IDLE` (serial clock at its idle level, lines quiet), `ST_LEAD` (first half of a serial clock), `ST_TRAIL` (second half) and `ST_DONE`, which never occurs and decodes like `ST_IDLE`. The transitions are:
- start: `ST_IDLE`→`ST_LEAD` when `en` is high. This captures the settings and loads the word.
- sample: `ST_LEAD`→`ST_TRAIL` at the end of a half period. The receive lines are captured.
- advance: `ST_TRAIL`→`ST_LEAD` at the end of a half period, either to present the next bit or to reload at the frame end while `en` is high.
- stop: `ST_TRAIL`→`ST_IDLE` at the end of the last half period of a frame when `en` is low.

Top module: `ssx_engine`

## Requirements
- R1: When `dual_lane` is 0, a frame lasts 16 serial clocks. `tx_lane[0]` sends the word most significant bit first, `rx_lane[0]` is captured most significant bit first, and `tx_lane[1]` stays 0.
- R2: When `dual_lane` is 1, a frame lasts 8 serial clocks. Lane 0 carries word bits 15:8 and lane 1 carries bits 7:0, each most significant bit first, in both directions.
- R3: With `div_fast` = 0 the serial clock period is 4 system clocks. With `div_fast` = 1 it is 2 system clocks. The serial clock changes level only at half-period boundaries.
- R4: With `cpol` = 0 the serial clock idles low; with `cpol` = 1 it idles high. While disabled it sits at that idle level.
- R5: With `cpha` = 0, data is sampled on the idle-to-active edge. With `cpha` = 1, it is sampled on the active-to-idle edge. Data changes on the other edge, and the first bit is present one half period before the first sampling edge, which follows the start by one half period.
- R6: `upd_sel` = k places update points every 2^k serial clocks, counted from the start. Values above 4 act as 4, which gives every 16 clocks.
- R7: When a frame ends on an update point, the received word appears on `rx_word` and `upd_strobe` is high for exactly one system clock. At no other time does `rx_word` change.
- R8: When a frame ends off an update point, `overrun` is high for one system clock, `rx_word` keeps its value, and `upd_strobe` stays low. This happens only for 8-clock frames with a 16-clock interval.
- R9: Lane mode, divider, polarity, phase and interval are captured at the start. Changes to them while the engine is running have no effect.
- R10: Frames repeat without a gap while `en` is high. When `en` is low at a frame's end, the engine stops after completing that frame.
- R11: After reset, the serial clock sits at the `cpol` level, both transmit lines are 0, `rx_word` is 0, and neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; sampled at each frame boundary |
| dual_lane | input | 1 | 0: one lane, 16 clocks; 1: two lanes, 8 clocks |
| div_fast | input | 1 | 0: system clock / 4; 1: system clock / 2 |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: on trailing edge |
| upd_sel | input | 3 | Update interval exponent (2^k serial clocks) |
| tx_word | input | 16 | Word to send, taken at frame start |
| rx_lane | input | 2 | Serial receive lines |
| sclk | output | 1 | Serial clock |
| tx_lane | output | 2 | Serial transmit lines |
| rx_word | output | 16 | Last published received word |
| upd_strobe | output | 1 | One-cycle pulse when `rx_word` is refreshed |
| overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The bench builds the engine with its default parameters: 16-bit words and dividers of 4 and 2. With these, the longest interval (16 clocks) is longer than the dual-lane frame (8 clocks), so the dropped-word path is reachable, and a full single-lane frame at the slow divider still takes only 64 system clocks. With both dividers small, the serial edge spacing and first-edge latency can be measured exactly in system clocks. Many combinations of polarity, phase, lane mode and interval can then run in a short bench.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int UPD_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_DONE  = 2'd3
    } ssx_state_e;

    typedef struct packed {
        logic             dual;
        logic             fast;
        logic             cpol;
        logic             cpha;
        logic [UPD_W-1:0] upd;
    } ssx_cfg_t;

endpackage

// File: rtl/ssx_halfgen.sv
module ssx_halfgen #(
    parameter int DIV_SLOW = 4,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic half_end
);
    localparam int H_SLOW = DIV_SLOW / 2;
    localparam int H_FAST = DIV_FAST / 2;
    localparam int CNT_W  = (H_SLOW > 1) ? $clog2(H_SLOW + 1) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim      = fast ? CNT_W'(H_FAST - 1) : CNT_W'(H_SLOW - 1);
        half_end = run && (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              sample,
    input  logic              active,
    input  logic              dual,
    input  logic [WORD_W-1:0] load_word,
    input  logic [1:0]        rx_lane,
    output logic [1:0]        tx_lane,
    output logic [WORD_W-1:0] rx_sh
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word;
        end else if (shift) begin
            if (dual) begin
                tx_sr <= {tx_sr[WORD_W-2:HALF], 1'b0, tx_sr[HALF-2:0], 1'b0};
            end else begin
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (sample) begin
            if (dual) begin
                rx_sh <= {rx_sh[WORD_W-2:HALF], rx_lane[0], rx_sh[HALF-2:0], rx_lane[1]};
            end else begin
                rx_sh <= {rx_sh[WORD_W-2:0], rx_lane[0]};
            end
        end
    end

    always_comb begin
        tx_lane[0] = active && tx_sr[WORD_W-1];
        tx_lane[1] = active && dual && tx_sr[HALF-1];
    end
endmodule

// File: rtl/ssx_engine.sv
module ssx_engine
    import ssx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int DIV_SLOW = 4,
    parameter int DIV_FAST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dual_lane,
    input  logic              div_fast,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [UPD_W-1:0]  upd_sel,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [1:0]        rx_lane,
    output logic              sclk,
    output logic [1:0]        tx_lane,
    output logic [WORD_W-1:0] rx_word,
    output logic              upd_strobe,
    output logic              overrun
);
    localparam int HALF = WORD_W / 2;
    localparam int CW   = $clog2(WORD_W);

    ssx_state_e        state_q, state_d;
    ssx_cfg_t          cfg_q;
    logic [CW-1:0]     bit_q, cyc_q, cyc_nxt;
    logic [CW:0]       ivl;
    logic              busy, half_end, last_bit, start;
    logic              sample_p, tick_end, frame_done, load, shift, upd_pt;
    logic [WORD_W-1:0] rx_sh;

    ssx_halfgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .fast     (cfg_q.fast),
        .half_end (half_end)
    );

    ssx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (shift),
        .sample    (sample_p),
        .active    (busy),
        .dual      (cfg_q.dual),
        .load_word (tx_word),
        .rx_lane   (rx_lane),
        .tx_lane   (tx_lane),
        .rx_sh     (rx_sh)
    );

    always_comb begin
        busy       = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
        last_bit   = bit_q == (cfg_q.dual ? CW'(HALF - 1) : CW'(WORD_W - 1));
        start      = (state_q == ST_IDLE) && en;
        sample_p   = (state_q == ST_LEAD) && half_end;
        tick_end   = (state_q == ST_TRAIL) && half_end;
        frame_done = tick_end && last_bit;
        load       = start || (frame_done && en);
        shift      = tick_end && !last_bit;
        cyc_nxt    = cyc_q + 1'b1;
        ivl        = (CW+1)'(1) << cfg_q.upd;
        upd_pt     = (({1'b0, cyc_nxt} & (ivl - (CW+1)'(1))) == '0);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_LEAD;
            ST_LEAD:  if (half_end) state_d = ST_TRAIL;
            ST_TRAIL: if (half_end) state_d = (last_bit && !en) ? ST_IDLE : ST_LEAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, captured settings and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            bit_q   <= '0;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cfg_q.dual <= dual_lane;
                cfg_q.fast <= div_fast;
                cfg_q.cpol <= cpol;
                cfg_q.cpha <= cpha;
                cfg_q.upd  <= (upd_sel > UPD_W'(CW)) ? UPD_W'(CW) : upd_sel;
                bit_q      <= '0;
                cyc_q      <= '0;
            end else if (tick_end) begin
                bit_q <= last_bit ? '0 : bit_q + 1'b1;
                cyc_q <= cyc_nxt;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word    <= '0;
            upd_strobe <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            upd_strobe <= frame_done && upd_pt;
            overrun    <= frame_done && !upd_pt;
            if (frame_done && upd_pt) begin
                rx_word <= rx_sh;
            end
        end
    end

    // serial clock level per state
    always_comb begin
        unique case (state_q)
            ST_LEAD:  sclk = cfg_q.cpol ^ cfg_q.cpha;
            ST_TRAIL: sclk = cfg_q.cpol ^ ~cfg_q.cpha;
            default:  sclk = cpol;
        endcase
    end
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
    parameter int WORD_W = 16,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              half_end,
    input logic              dual_s,
    input logic [2:0]        upd_s,
    input logic              cpol,
    input logic              sclk,
    input logic [1:0]        tx_lane,
    input logic [WORD_W-1:0] rx_word,
    input logic              upd_strobe,
    input logic              overrun
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol); // R4

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(half_end) |-> $stable(sclk)); // R3

    AST_LANE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !dual_s |-> tx_lane[1] == 1'b0); // R1

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe); // R7

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |-> $stable(rx_word)); // R7

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_strobe && overrun)); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> dual_s && (upd_s == 3'(CW))); // R8
endmodule

bind ssx_engine ssx_checker #(.WORD_W(WORD_W), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .half_end   (half_end),
    .dual_s     (cfg_q.dual),
    .upd_s      (cfg_q.upd),
    .cpol       (cpol),
    .sclk       (sclk),
    .tx_lane    (tx_lane),
    .rx_word    (rx_word),
    .upd_strobe (upd_strobe),
    .overrun    (overrun)
);

// File: tb/ssx_engine_tb.sv
module ssx_engine_tb;
    localparam int W    = 16;
    localparam int HALF = W / 2;

    typedef struct packed {
        logic        dual;
        logic        fast;
        logic        cpol;
        logic        cpha;
        logic [2:0]  upd;
        logic [15:0] tx;
        logic [15:0] rx;
        logic [3:0]  nfr;
        logic [3:0]  strb;
        logic [3:0]  ovr;
    } vec_t;

    // dual fast cpol cpha upd tx rx frames strobes overruns
    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'hA5C3, 16'h3C5A, 4'd2, 4'd2, 4'd0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 16'h1234, 16'hFEDC, 4'd2, 4'd2, 4'd0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 16'h8001, 16'h7FFE, 4'd2, 4'd2, 4'd0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 16'hBEEF, 16'h0F0F, 4'd2, 4'd1, 4'd1},
        '{1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 16'hC0DE, 16'h5A5A, 4'd2, 4'd2, 4'd0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 16'hFFFF, 16'h0000, 4'd3, 4'd3, 4'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         dual_lane = 1'b0;
    logic         div_fast = 1'b0;
    logic         cpol = 1'b0;
    logic         cpha = 1'b0;
    logic [2:0]   upd_sel = 3'd0;
    logic [W-1:0] tx_word = '0;
    logic [1:0]   rx_lane = 2'b00;
    logic         sclk;
    logic [1:0]   tx_lane;
    logic [W-1:0] rx_word;
    logic         upd_strobe, overrun;

    always #10 clk = ~clk;

    ssx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .dual_lane(dual_lane),
        .div_fast(div_fast), .cpol(cpol), .cpha(cpha), .upd_sel(upd_sel),
        .tx_word(tx_word), .rx_lane(rx_lane), .sclk(sclk), .tx_lane(tx_lane),
        .rx_word(rx_word), .upd_strobe(upd_strobe), .overrun(overrun)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected settings, as the bench believes them
    logic         e_dual = 1'b0, e_cpol = 1'b0, e_cpha = 1'b0;
    int           e_h = 2;
    logic [W-1:0] e_tx = '0, e_rx = '0;

    // serial-side monitor: acts as the far end of the link
    int           n_samp = 0, n_frames = 0, n_strb = 0, n_ovr = 0;
    int           tx_bad = 0, rx_bad = 0, gap_bad = 0, lat_bad = 0;
    int           k = 0;
    logic [W-1:0] cap = '0;
    time          t_prev = 0, t_en = 0;
    logic         en_d = 1'b0, sclk_d = 1'b0, first = 1'b0, armed = 1'b0;

    always @(negedge clk) begin
        if (en && !en_d) begin
            k = 0; first = 1'b1; armed = 1'b1; t_en = $time;
            rx_lane = e_dual ? {e_rx[HALF-1], e_rx[W-1]} : {1'b0, e_rx[W-1]};
        end
        en_d = en;
        if (armed && rst_n && (sclk !== sclk_d) && (sclk == (e_cpha ? e_cpol : !e_cpol))) begin
            n_samp++;
            if (first) begin
                if ($time - t_en != time'(20 * (e_h + 1))) lat_bad++;
                first = 1'b0;
            end else if ($time - t_prev != time'(40 * e_h)) begin
                gap_bad++;
            end
            t_prev = $time;
            if (e_dual) cap = {cap[W-2:HALF], tx_lane[0], cap[HALF-2:0], tx_lane[1]};
            else        cap = {cap[W-2:0], tx_lane[0]};
            if (k == (e_dual ? HALF - 1 : W - 1)) begin
                n_frames++;
                if (cap !== e_tx) tx_bad++;
                k = 0;
                if (!en) armed = 1'b0;
            end else begin
                k++;
            end
            rx_lane = e_dual ? {e_rx[HALF-1-k], e_rx[W-1-k]} : {1'b0, e_rx[W-1-k]};
        end
        sclk_d = sclk;
        if (upd_strobe) begin
            n_strb++;
            if (rx_word !== e_rx) rx_bad++;
        end
        if (overrun) n_ovr++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic run(input vec_t v, input bit perturb);
        int s_samp, s_fr, s_strb, s_ovr, s_tx, s_rx, s_gap, s_lat, len, target;
        bit flipped, restored;
        step(1);
        dual_lane = v.dual; div_fast = v.fast; cpol = v.cpol; cpha = v.cpha;
        upd_sel = v.upd; tx_word = v.tx;
        e_dual = v.dual; e_cpol = v.cpol; e_cpha = v.cpha;
        e_h = v.fast ? 1 : 2; e_tx = v.tx; e_rx = v.rx;
        step(3);
        s_samp = n_samp; s_fr = n_frames; s_strb = n_strb; s_ovr = n_ovr;
        s_tx = tx_bad; s_rx = rx_bad; s_gap = gap_bad; s_lat = lat_bad;
        len = v.dual ? HALF : W;
        target = s_samp + (int'(v.nfr) - 1) * len + 1;
        flipped = 1'b0; restored = 1'b0;
        en = 1'b1;
        while (n_samp < target) begin
            step(1);
            if (perturb && !flipped && n_samp >= s_samp + 1) begin
                dual_lane = ~v.dual; div_fast = ~v.fast; cpol = ~v.cpol;
                cpha = ~v.cpha; upd_sel = 3'd4; flipped = 1'b1;
            end
            if (perturb && flipped && !restored && n_samp >= s_samp + 4) begin
                dual_lane = v.dual; div_fast = v.fast; cpol = v.cpol;
                cpha = v.cpha; upd_sel = v.upd; restored = 1'b1;
            end
        end
        en = 1'b0;
        step(4 * e_h * len + 10);
        check(n_frames - s_fr == int'(v.nfr), "R10", "frame count", n_frames - s_fr, int'(v.nfr));
        check(tx_bad == s_tx, v.dual ? "R2" : "R1", "tx frame mismatches", tx_bad - s_tx, 0);
        check(rx_bad == s_rx, "R7", "rx word at strobe mismatches", rx_bad - s_rx, 0);
        check(gap_bad == s_gap, "R3", "sampling edge spacing errors", gap_bad - s_gap, 0);
        check(lat_bad == s_lat, "R5", "first sampling edge latency errors", lat_bad - s_lat, 0);
        check(n_strb - s_strb == int'(v.strb), "R6", "update strobes", n_strb - s_strb, int'(v.strb));
        check(n_ovr - s_ovr == int'(v.ovr), "R8", "overruns", n_ovr - s_ovr, int'(v.ovr));
        check(sclk == v.cpol, "R4", "idle serial clock level", sclk, v.cpol);
        if (v.strb != 0)
            check(rx_word == v.rx, v.dual ? "R2" : "R1", "published word", rx_word, v.rx);
        if (perturb)
            check(tx_bad == s_tx && n_frames - s_fr == int'(v.nfr), "R9",
                  "frames with settings changed mid-run", tx_bad - s_tx, 0);
    endtask

    initial begin
        step(3);
        check(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
        check(tx_lane == 2'b00, "R11", "tx lanes after reset", tx_lane, 0);
        check(rx_word == '0, "R11", "rx_word after reset", rx_word, 0);
        check(!upd_strobe && !overrun, "R11", "strobes after reset", {upd_strobe, overrun}, 0);
        rst_n = 1'b1;
        step(2);
        check(tx_lane == 2'b00 && sclk == 1'b0, "R11", "idle after release", {sclk, tx_lane}, 0);

        for (int i = 0; i < 6; i++) begin
            run(VEC[i], 1'b0);
        end

        // R9: settings changed while running are ignored
        run('{1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h9C31, 16'h6E17, 4'd2, 4'd2, 4'd0}, 1'b1);
        // R8: long interval with short frames, four frames alternate
        run('{1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 16'h4D2B, 16'hE1C7, 4'd4, 4'd2, 4'd2}, 1'b0);
        // R6: out-of-range interval code acts as 16 clocks
        run('{1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 16'h0FF0, 16'hA0B1, 4'd2, 4'd1, 4'd1}, 1'b0);
        // R1: single lane with one frame only
        run('{1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 16'h8000, 16'h0001, 4'd1, 4'd1, 4'd0}, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end
endmodule